// File: doc/BRIEF.md
# Shared Register Read-Port Allocator

This block decides which read ports of a 192-entry physical register file serve the source operands of up to four instructions leaving rename in the same cycle. Each instruction slot can carry up to four source operands, which would take sixteen read ports if every operand had its own. The register file has twelve. Eight of them are bound in pairs to the four slots. The other four form a pool that slots draw on when they need more than their own two.

Every cycle the block takes a valid bit per slot, a need bit per operand and an 8-bit physical register address per operand. An operand that does not need a read, such as an immediate or a bypassed value, has its need bit low and takes no port. The block first serves each slot from its own pair of ports, then hands out the pool in age order with slot 0 oldest. A slot is granted only when every operand it needs has a port. The first slot that cannot be fully served stalls, and every younger valid slot stalls with it. Grants, stalls, a port index per operand and the address and enable per port are registered, so they appear one cycle after the request.

Top module: `rpa_read_port_alloc`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is zero on the following cycle.
- R2: An operand whose `op_need` bit is 0, or that belongs to a slot that is not granted, has `op_port_vld` 0 and `op_port` 0, and takes no port.
- R3: In a granted slot s, the first needed operand in operand-index order uses port 2*s and the second uses port 2*s+1.
- R4: The third and fourth needed operands of a granted slot use pool ports 8 to 11. The pool is handed out upward from port 8, to older slots before younger ones, and in operand-index order within a slot.
- R5: A valid slot is granted only when the pool ports its third and fourth operands need are still free. A valid slot with at most two needed operands is granted unless an older slot is stalled.
- R6: Once a valid slot stalls, every younger valid slot in the same cycle also stalls, even if the pool could have served it.
- R7: `slot_stall` is high exactly for valid slots that are not granted. A slot whose `slot_valid` bit is 0 shows neither grant nor stall.
- R8: `port_en[p]` is high exactly when some granted operand was given port p. `port_addr` field p (bits 8p+7 to 8p) then carries that operand's address and is otherwise 0. No port is given to two operands.
- R9: All outputs are registered. They reflect the inputs sampled at the previous rising clock edge and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | 4 | Bit s: slot s holds an instruction this cycle |
| op_need | input | 16 | Bit 4*s+o: operand o of slot s needs a register read |
| op_addr | input | 128 | Field 4*s+o (8 bits): physical register of that operand |
| slot_grant | output | 4 | Bit s: slot s gets all its ports this cycle |
| slot_stall | output | 4 | Bit s: valid slot s must hold |
| op_port_vld | output | 16 | Bit 4*s+o: that operand was given a port |
| op_port | output | 64 | Field 4*s+o (4 bits): port index given to that operand |
| port_en | output | 12 | Bit p: read port p is used |
| port_addr | output | 96 | Field p (8 bits): register address presented to port p |

## Verification
Each result is due one full cycle after its request. The request is driven on a falling edge and captured at the next rising edge, and the outputs are compared at the falling edge after that. One nanosecond after each new request is driven, the bench also checks that the outputs still show the previous request's expected values, which proves that nothing propagates combinationally. The sweep covers every mix of per-slot operand counts from 0 to 4 under all sixteen slot-valid patterns, with rotating need masks and addresses. This drives the pool through exact fits, overflow at each slot position, and stall chains that pass over empty slots.

// File: rtl/rpa_pkg.sv
package rpa_pkg;

    localparam int NUM_SLOTS    = 4;
    localparam int OPS_PER_SLOT = 4;
    localparam int DED_PER_SLOT = 2;
    localparam int POOL_PORTS   = 4;
    localparam int PREG_COUNT   = 192;

    localparam int NUM_OPS   = NUM_SLOTS * OPS_PER_SLOT;
    localparam int POOL_BASE = NUM_SLOTS * DED_PER_SLOT;
    localparam int NUM_PORTS = POOL_BASE + POOL_PORTS;
    localparam int AW        = $clog2(PREG_COUNT);
    localparam int PW        = $clog2(NUM_PORTS);
    localparam int CW        = $clog2(OPS_PER_SLOT + 1);
    localparam int SW        = $clog2(POOL_PORTS + 1);

    typedef logic [AW-1:0] preg_t;
    typedef logic [PW-1:0] port_idx_t;
    typedef logic [CW-1:0] op_cnt_t;
    typedef logic [SW-1:0] pool_cnt_t;

    typedef struct packed {
        logic      vld;
        port_idx_t idx;
    } op_route_t;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_GO   = 2'd1,
        SLOT_HOLD = 2'd2
    } slot_state_e;

    // Operands beyond the dedicated pair must come from the pool.
    function automatic pool_cnt_t pool_share(input op_cnt_t total);
        if (total > op_cnt_t'(DED_PER_SLOT))
            return pool_cnt_t'(total - op_cnt_t'(DED_PER_SLOT));
        return '0;
    endfunction

endpackage

// File: rtl/rpa_slot_demand.sv
module rpa_slot_demand
    import rpa_pkg::*;
(
    input  logic                             slot_valid,
    input  logic [OPS_PER_SLOT-1:0]          need,
    output logic [OPS_PER_SLOT-1:0][CW-1:0]  rank,
    output pool_cnt_t                        extra
);

    op_cnt_t total;

    // rank[o] = number of needed operands with a lower index
    always_comb begin
        op_cnt_t run;
        run = '0;
        for (int o = 0; o < OPS_PER_SLOT; o++) begin
            rank[o] = run;
            if (need[o])
                run = run + op_cnt_t'(1);
        end
        total = run;
    end

    assign extra = slot_valid ? pool_share(total) : '0;

endmodule

// File: rtl/rpa_pool_arbiter.sv
module rpa_pool_arbiter
    import rpa_pkg::*;
(
    input  logic [NUM_SLOTS-1:0]             slot_valid,
    input  pool_cnt_t [NUM_SLOTS-1:0]        extra,
    output logic [NUM_SLOTS-1:0]             grant,
    output logic [NUM_SLOTS-1:0]             stall,
    output pool_cnt_t [NUM_SLOTS-1:0]        base
);

    slot_state_e [NUM_SLOTS-1:0] state;

    // Age-ordered walk: slot 0 is oldest; first miss blocks the rest.
    always_comb begin
        logic      blocked;
        pool_cnt_t left;
        pool_cnt_t used;
        blocked = 1'b0;
        left    = pool_cnt_t'(POOL_PORTS);
        used    = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            state[s] = SLOT_IDLE;
            base[s]  = used;
            if (slot_valid[s]) begin
                if (!blocked && (extra[s] <= left)) begin
                    state[s] = SLOT_GO;
                    left     = left - extra[s];
                    used     = used + extra[s];
                end else begin
                    state[s] = SLOT_HOLD;
                    blocked  = 1'b1;
                end
            end
        end
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_out
        assign grant[s] = (state[s] == SLOT_GO);
        assign stall[s] = (state[s] == SLOT_HOLD);
    end

endmodule

// File: rtl/rpa_port_steer.sv
module rpa_port_steer
    import rpa_pkg::*;
(
    input  logic [NUM_SLOTS-1:0]             grant,
    input  logic [NUM_OPS-1:0]               need,
    input  logic [NUM_OPS-1:0][CW-1:0]       rank,
    input  pool_cnt_t [NUM_SLOTS-1:0]        base,
    input  preg_t [NUM_OPS-1:0]              addr,
    output op_route_t [NUM_OPS-1:0]          route,
    output preg_t [NUM_PORTS-1:0]            port_addr,
    output logic [NUM_PORTS-1:0]             port_en
);

    // Operand -> port index
    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            for (int o = 0; o < OPS_PER_SLOT; o++) begin
                route[s*OPS_PER_SLOT+o] = '0;
                if (grant[s] && need[s*OPS_PER_SLOT+o]) begin
                    route[s*OPS_PER_SLOT+o].vld = 1'b1;
                    if (rank[s*OPS_PER_SLOT+o] < op_cnt_t'(DED_PER_SLOT))
                        route[s*OPS_PER_SLOT+o].idx =
                            PW'(s*DED_PER_SLOT) + PW'(rank[s*OPS_PER_SLOT+o]);
                    else
                        route[s*OPS_PER_SLOT+o].idx =
                            PW'(POOL_BASE) + PW'(base[s])
                            + PW'(rank[s*OPS_PER_SLOT+o]) - PW'(DED_PER_SLOT);
                end
            end
        end
    end

    // Port -> address mux (one-hot by construction of the routing)
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        preg_t a;
        logic  e;
        always_comb begin
            a = '0;
            e = 1'b0;
            for (int i = 0; i < NUM_OPS; i++) begin
                if (route[i].vld && (route[i].idx == PW'(p))) begin
                    a = a | addr[i];
                    e = 1'b1;
                end
            end
        end
        assign port_addr[p] = a;
        assign port_en[p]   = e;
    end

endmodule

// File: rtl/rpa_read_port_alloc.sv
module rpa_read_port_alloc
    import rpa_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_SLOTS-1:0]     slot_valid,
    input  logic [NUM_OPS-1:0]       op_need,
    input  logic [NUM_OPS*AW-1:0]    op_addr,
    output logic [NUM_SLOTS-1:0]     slot_grant,
    output logic [NUM_SLOTS-1:0]     slot_stall,
    output logic [NUM_OPS-1:0]       op_port_vld,
    output logic [NUM_OPS*PW-1:0]    op_port,
    output logic [NUM_PORTS-1:0]     port_en,
    output logic [NUM_PORTS*AW-1:0]  port_addr
);

    logic [NUM_OPS-1:0][CW-1:0]  rank_all;
    pool_cnt_t [NUM_SLOTS-1:0]   extra;
    pool_cnt_t [NUM_SLOTS-1:0]   base;
    logic [NUM_SLOTS-1:0]        grant_c, stall_c;
    preg_t [NUM_OPS-1:0]         addr_v;
    op_route_t [NUM_OPS-1:0]     route_c, route_q;
    preg_t [NUM_PORTS-1:0]       paddr_c, paddr_q;
    logic [NUM_PORTS-1:0]        pen_c, pen_q;
    logic [NUM_SLOTS-1:0]        grant_q, stall_q;

    assign addr_v = op_addr;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        rpa_slot_demand i_demand (
            .slot_valid (slot_valid[s]),
            .need       (op_need[s*OPS_PER_SLOT +: OPS_PER_SLOT]),
            .rank       (rank_all[s*OPS_PER_SLOT +: OPS_PER_SLOT]),
            .extra      (extra[s])
        );
    end

    rpa_pool_arbiter i_arb (
        .slot_valid (slot_valid),
        .extra      (extra),
        .grant      (grant_c),
        .stall      (stall_c),
        .base       (base)
    );

    rpa_port_steer i_steer (
        .grant     (grant_c),
        .need      (op_need),
        .rank      (rank_all),
        .base      (base),
        .addr      (addr_v),
        .route     (route_c),
        .port_addr (paddr_c),
        .port_en   (pen_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            stall_q <= '0;
            route_q <= '0;
            paddr_q <= '0;
            pen_q   <= '0;
        end else begin
            grant_q <= grant_c;
            stall_q <= stall_c;
            route_q <= route_c;
            paddr_q <= paddr_c;
            pen_q   <= pen_c;
        end
    end

    assign slot_grant = grant_q;
    assign slot_stall = stall_q;
    assign port_en    = pen_q;
    assign port_addr  = paddr_q;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
        assign op_port_vld[i]        = route_q[i].vld;
        assign op_port[i*PW +: PW]   = route_q[i].idx;
    end

endmodule

// File: rtl/rpa_checker.sv
module rpa_checker
    import rpa_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_SLOTS-1:0]  slot_valid,
    input logic [NUM_OPS-1:0]    op_need,
    input logic [NUM_SLOTS-1:0]  slot_grant,
    input logic [NUM_SLOTS-1:0]  slot_stall,
    input logic [NUM_OPS-1:0]    op_port_vld,
    input logic [NUM_PORTS-1:0]  port_en
);

    logic [NUM_SLOTS-1:0] valid_d;
    always_ff @(posedge clk) begin
        if (rst) valid_d <= '0;
        else     valid_d <= slot_valid;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (slot_grant == '0 && slot_stall == '0 && port_en == '0 && op_port_vld == '0));

    assert_no_need_R2: assert property (@(posedge clk) disable iff (rst)
        (op_need == '0) |=> (op_port_vld == '0 && port_en == '0));

    assert_slot0_small_R5: assert property (@(posedge clk) disable iff (rst)
        (slot_valid[0] && $countones(op_need[OPS_PER_SLOT-1:0]) <= DED_PER_SLOT) |=> slot_grant[0]);

    assert_grant_stall_excl_R7: assert property (@(posedge clk) disable iff (rst)
        (slot_grant & slot_stall) == '0);

    assert_idle_slots_R7: assert property (@(posedge clk) disable iff (rst)
        (slot_valid == '0) |=> (slot_grant == '0 && slot_stall == '0));

    assert_port_once_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(port_en) == $countones(op_port_vld));

    for (genvar s = 1; s < NUM_SLOTS; s++) begin : g_chain
        assert_stall_chain_R6: assert property (@(posedge clk) disable iff (rst)
            (slot_stall[s-1] && valid_d[s]) |-> slot_stall[s]);
    end

    for (genvar k = 1; k < POOL_PORTS; k++) begin : g_pack
        assert_pool_packed_R4: assert property (@(posedge clk) disable iff (rst)
            port_en[POOL_BASE+k] |-> port_en[POOL_BASE+k-1]);
    end

endmodule

bind rpa_read_port_alloc rpa_checker i_chk (
    .clk         (clk),
    .rst         (rst),
    .slot_valid  (slot_valid),
    .op_need     (op_need),
    .slot_grant  (slot_grant),
    .slot_stall  (slot_stall),
    .op_port_vld (op_port_vld),
    .port_en     (port_en)
);

// File: tb/test_rpa_read_port_alloc.sv
module test_rpa_read_port_alloc;
    import rpa_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic                     rst;
    logic [NUM_SLOTS-1:0]     slot_valid;
    logic [NUM_OPS-1:0]       op_need;
    logic [NUM_OPS*AW-1:0]    op_addr;
    logic [NUM_SLOTS-1:0]     slot_grant, slot_stall;
    logic [NUM_OPS-1:0]       op_port_vld;
    logic [NUM_OPS*PW-1:0]    op_port;
    logic [NUM_PORTS-1:0]     port_en;
    logic [NUM_PORTS*AW-1:0]  port_addr;

    rpa_read_port_alloc i_rpa_read_port_alloc (
        .clk(clk), .rst(rst), .slot_valid(slot_valid), .op_need(op_need),
        .op_addr(op_addr), .slot_grant(slot_grant), .slot_stall(slot_stall),
        .op_port_vld(op_port_vld), .op_port(op_port), .port_en(port_en),
        .port_addr(port_addr)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [NUM_SLOTS-1:0]     e_grant, e_stall;
    logic [NUM_OPS-1:0]       e_vld;
    logic [NUM_OPS*PW-1:0]    e_port;
    logic [NUM_PORTS-1:0]     e_en;
    logic [NUM_PORTS*AW-1:0]  e_addr;

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected outputs from the requirements for the currently driven inputs.
    task automatic model();
        int  pool_left;
        int  pool_next;
        bit  held;
        e_grant = '0; e_stall = '0; e_vld = '0; e_port = '0; e_en = '0; e_addr = '0;
        pool_left = POOL_PORTS;
        pool_next = 0;
        held      = 0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            int n;
            int k;
            n = 0;
            for (int o = 0; o < OPS_PER_SLOT; o++) n += int'(op_need[s*OPS_PER_SLOT+o]);
            if (!slot_valid[s]) continue;                       // R7
            if (held || (n - DED_PER_SLOT) > pool_left) begin    // R5, R6
                e_stall[s] = 1'b1;
                held = 1;
                continue;
            end
            e_grant[s] = 1'b1;
            k = 0;
            for (int o = 0; o < OPS_PER_SLOT; o++) begin
                int i;
                int p;
                i = s*OPS_PER_SLOT + o;
                if (op_need[i]) begin
                    if (k < DED_PER_SLOT) p = s*DED_PER_SLOT + k;     // R3
                    else begin p = POOL_BASE + pool_next; pool_next++; end  // R4
                    e_vld[i] = 1'b1;
                    e_port[i*PW +: PW] = PW'(p);
                    e_en[p] = 1'b1;
                    e_addr[p*AW +: AW] = op_addr[i*AW +: AW];
                    k++;
                end
            end
            if (n > DED_PER_SLOT) pool_left -= (n - DED_PER_SLOT);
        end
    endtask

    function automatic logic [OPS_PER_SLOT-1:0] pick_mask(input int cnt, input int sel);
        int hits;
        int want;
        hits = 0;
        for (int m = 0; m < (1 << OPS_PER_SLOT); m++)
            if ($countones(m[OPS_PER_SLOT-1:0]) == cnt) hits++;
        want = sel % hits;
        for (int m = 0; m < (1 << OPS_PER_SLOT); m++) begin
            if ($countones(m[OPS_PER_SLOT-1:0]) == cnt) begin
                if (want == 0) return m[OPS_PER_SLOT-1:0];
                want--;
            end
        end
        return '0;
    endfunction

    task automatic compare_all();
        check("R5/R6 slot_grant", 128'(slot_grant), 128'(e_grant));
        check("R7 slot_stall", 128'(slot_stall), 128'(e_stall));
        check("R2 op_port_vld", 128'(op_port_vld), 128'(e_vld));
        for (int i = 0; i < NUM_OPS; i++) begin
            if (!e_vld[i])
                check("R2 op_port idle", 128'(op_port[i*PW +: PW]), 128'(0));
            else if (int'(e_port[i*PW +: PW]) < POOL_BASE)
                check("R3 dedicated port", 128'(op_port[i*PW +: PW]), 128'(e_port[i*PW +: PW]));
            else
                check("R4 pool port", 128'(op_port[i*PW +: PW]), 128'(e_port[i*PW +: PW]));
        end
        check("R8 port_en", 128'(port_en), 128'(e_en));
        check("R8 port_addr", 128'(port_addr), 128'(e_addr));
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        rst = 1'b1;
        slot_valid = '0;
        op_need = '0;
        op_addr = '0;
        repeat (3) @(negedge clk);
        check("R1 reset outputs",
              {slot_grant, slot_stall, op_port_vld, port_en}, 128'(0));
        check("R1 reset ports", 128'(op_port), 128'(0));
        check("R1 reset addrs", 128'(port_addr), 128'(0));
        model();   // all-zero inputs -> all-zero expectation
        rst = 1'b0;
        for (int idx = 0; idx < 625; idx++) begin
            for (int v = 0; v < 16; v++) begin
                logic [NUM_SLOTS-1:0] pg, ps;
                logic [NUM_PORTS-1:0] pe;
                @(negedge clk);
                pg = e_grant; ps = e_stall; pe = e_en;
                slot_valid = NUM_SLOTS'(v);
                for (int s = 0; s < NUM_SLOTS; s++) begin
                    int c;
                    c = (idx / (5 ** s)) % 5;
                    op_need[s*OPS_PER_SLOT +: OPS_PER_SLOT] = pick_mask(c, idx + v + s);
                end
                for (int i = 0; i < NUM_OPS; i++)
                    op_addr[i*AW +: AW] = AW'((i*37 + idx*7 + v*13) % PREG_COUNT);
                #1;
                // R9: new inputs are not visible before the next rising edge
                check("R9 hold until edge", {slot_grant, slot_stall, port_en},
                      {pg, ps, pe});
                model();
                @(negedge clk);
                compare_all();
            end
        end
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule